// File: doc/BRIEF.md
# Barrel Rotate-Right Unit

This block rotates a data word to the right by a variable number of bit positions. Each bit that leaves the least-significant end comes back in at the most-significant end. The default word is 16 bits wide and the amount is 4 bits wide. The result is the same as taking the word shifted right by the amount and ORing it with the word shifted left by the width minus the amount. No shift operator produces it.

The unit is a chain of 2:1 multiplexer stages, one stage for each bit of the amount. Stage k takes the output of stage k-1. When amount bit k is 1, the stage passes on that value rotated right by 2^k positions. When the bit is 0, the stage passes the value through unchanged. Each fixed rotation is plain wiring, built as index arithmetic. The block has no clock and no state, so a datapath can place it directly between registers.

Top module: `rotr_unit`

## Requirements
- R1: When the amount is 0, the output equals the data input bit for bit.
- R2: For every amount a in 0..15 and every data word, output bit i equals input bit (i + a) mod 16.
- R3: Rotating 16'b1011010101110011 (0xB573) by 5 gives 16'b1001110110101011 (0x9DAB).
- R4: The output contains the same number of 1 bits as the data input.
- R5: The output follows a change of either input with no clock edge in between, so there is zero cycles of latency.
- R6: An amount with exactly one bit k set (1, 2, 4 or 8) rotates right by exactly 2^k positions.
- R7: Rotating the output for amount a again by amount b gives the same word as rotating the original input once by (a + b) mod 16.
- R8: An all-zeros or an all-ones data word comes out unchanged for every amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 16 | Word to be rotated |
| amt_i | input | 4 | Rotate distance toward the least-significant end |
| data_o | output | 16 | Rotated word |

## Verification
The unit has no registers, so every result is due in the same cycle as the stimulus that causes it. The bench applies new inputs on the falling clock edge. It reads data_o a quarter period later, which is before any rising edge and away from both edges. The rising edges drive nothing in the design and only pace the run. The check for R5 changes the inputs and reads the output again before the next clock edge. The check for R7 feeds an observed output back into the data input within the same cycle.

// File: rtl/rotr_pkg.sv
package rotr_pkg;
  // Default datapath width; must be a power of two.
  parameter int unsigned ROTR_DEFAULT_W = 16;
endpackage

// File: rtl/rotr_fixed.sv
// Fixed-distance right rotation expressed as pure wiring.
module rotr_fixed #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DIST  = 1
) (
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign d_o[i] = d_i[(i + DIST) % WIDTH];
  end
endmodule

// File: rtl/rotr_mux2.sv
// Word-wide 2:1 selector.
module rotr_mux2 #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    if (sel_i) y_o = b_i;
    else       y_o = a_i;
  end
endmodule

// File: rtl/rotr_stage.sv
// One cascade stage: conditional rotation by a power-of-two distance.
module rotr_stage #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DIST  = 1
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);
  logic [WIDTH-1:0] rotated;

  rotr_fixed #(.WIDTH(WIDTH), .DIST(DIST)) fixed_i (
    .d_i (d_i),
    .d_o (rotated)
  );

  rotr_mux2 #(.WIDTH(WIDTH)) mux_i (
    .sel_i (en_i),
    .a_i   (d_i),
    .b_i   (rotated),
    .y_o   (d_o)
  );
endmodule

// File: rtl/rotr_unit.sv
// Variable right rotation built from log2(WIDTH) cascaded mux stages.
module rotr_unit #(
  parameter  int unsigned WIDTH = rotr_pkg::ROTR_DEFAULT_W,
  localparam int unsigned AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [WIDTH-1:0] data_o
);
  // stage_d[k] feeds stage k; stage_d[AMT_W] is the result.
  logic [WIDTH-1:0] stage_d [AMT_W+1];

  assign stage_d[0] = data_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    rotr_stage #(.WIDTH(WIDTH), .DIST(2 ** k)) stage_i (
      .en_i (amt_i[k]),
      .d_i  (stage_d[k]),
      .d_o  (stage_d[k+1])
    );
  end

  assign data_o = stage_d[AMT_W];
endmodule

// File: rtl/rotr_unit_chk.sv
// Property checker for rotr_unit, attached through bind.
module rotr_unit_chk #(
  parameter  int unsigned WIDTH = rotr_pkg::ROTR_DEFAULT_W,
  localparam int unsigned AMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] data_i,
  input logic [AMT_W-1:0] amt_i,
  input logic [WIDTH-1:0] data_o
);
  logic [AMT_W-1:0] lsb_src;
  logic [AMT_W-1:0] msb_src;

  assign lsb_src = amt_i;
  assign msb_src = amt_i + AMT_W'(WIDTH - 1);

  always_comb begin
    // R1: zero amount passes data through
    p_zero_amt_r1: assert (amt_i != '0 || data_o == data_i);
    // R2: end bits come from the expected source positions
    p_lsb_src_r2: assert (data_o[0] == data_i[lsb_src]);
    p_msb_src_r2: assert (data_o[WIDTH-1] == data_i[msb_src]);
    // R4: population count is preserved
    p_ones_kept_r4: assert ($countones(data_o) == $countones(data_i));
    // R8: uniform words are invariant
    p_uniform_r8: assert (!(data_i == '0 || data_i == '1) || data_o == data_i);
  end
endmodule

bind rotr_unit rotr_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .data_i (data_i),
  .amt_i  (amt_i),
  .data_o (data_o)
);

// File: tb/rotr_unit_tb_top.sv
module rotr_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int AW = 4;
  localparam int NVEC = 12;

  // {data, amount, expected}
  localparam logic [35:0] VEC [NVEC] = '{
    {16'hB573, 4'd5,  16'h9DAB},
    {16'h0001, 4'd1,  16'h8000},
    {16'h8000, 4'd15, 16'h0001},
    {16'h1234, 4'd4,  16'h4123},
    {16'h1234, 4'd8,  16'h3412},
    {16'h1234, 4'd12, 16'h2341},
    {16'h00FF, 4'd4,  16'hF00F},
    {16'hABCD, 4'd0,  16'hABCD},
    {16'h0003, 4'd1,  16'h8001},
    {16'hF0F0, 4'd2,  16'h3C3C},
    {16'h8001, 4'd3,  16'h3000},
    {16'hFFFF, 4'd7,  16'hFFFF}
  };

  logic clk;
  logic rst_n;
  logic [W-1:0]  data_i;
  logic [AW-1:0] amt_i;
  logic [W-1:0]  data_o;
  int n_checks;
  int n_fails;

  rotr_unit dut_i (
    .data_i (data_i),
    .amt_i  (amt_i),
    .data_o (data_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] ref_rot(input logic [W-1:0] d, input int a);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = d[(i + a) % W];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: data=%h amt=%0d actual=%h expected=%h", req, data_i, amt_i, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    data_i = d;
    amt_i  = a;
    #(CLK_PERIOD/4);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] first;
    logic [W-1:0] d;
    n_checks = 0;
    n_fails  = 0;
    rst_n  = 1'b0;
    data_i = '0;
    amt_i  = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: zero inputs give zero output (R1, R8)
    apply(16'h0000, 4'd0);
    check("R1", data_o, 16'h0000);

    // Vector table (R2; first entry is R3)
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][35:20], VEC[v][19:16]);
      check(v == 0 ? "R3" : "R2", data_o, VEC[v][15:0]);
    end

    // R1: amount zero passes several words
    apply(16'h5A3C, 4'd0);
    check("R1", data_o, 16'h5A3C);
    apply(16'h8000, 4'd0);
    check("R1", data_o, 16'h8000);

    // R6: single-bit amounts rotate by powers of two
    for (int k = 0; k < AW; k++) begin
      apply(16'h0001, AW'(1 << k));
      check("R6", data_o, ref_rot(16'h0001, 1 << k));
      apply(16'hC5A1, AW'(1 << k));
      check("R6", data_o, ref_rot(16'hC5A1, 1 << k));
    end

    // R8: uniform words for every amount
    for (int a = 0; a < W; a++) begin
      apply(16'h0000, AW'(a));
      check("R8", data_o, 16'h0000);
      apply(16'hFFFF, AW'(a));
      check("R8", data_o, 16'hFFFF);
    end

    // R5: output follows inputs with no clock edge in between
    apply(16'h1234, 4'd4);
    check("R5", data_o, 16'h4123);
    amt_i = 4'd8;
    #1;
    check("R5", data_o, 16'h3412);
    data_i = 16'hB573;
    amt_i  = 4'd5;
    #1;
    check("R5", data_o, 16'h9DAB);

    // R2, R4: all amounts over random words
    for (int a = 0; a < W; a++) begin
      for (int n = 0; n < 64; n++) begin
        d = W'($urandom);
        apply(d, AW'(a));
        check("R2", data_o, ref_rot(d, a));
        n_checks++;
        if ($countones(data_o) != $countones(d)) begin
          n_fails++;
          $display("FAIL R4: actual=%0d expected=%0d", $countones(data_o), $countones(d));
        end
      end
    end

    // R7: two rotations compose by modular addition
    for (int n = 0; n < 32; n++) begin
      int a;
      int b;
      d = W'($urandom);
      a = int'($urandom % W);
      b = int'($urandom % W);
      apply(d, AW'(a));
      first = data_o;
      data_i = first;
      amt_i  = AW'(b);
      #1;
      check("R7", data_o, ref_rot(d, (a + b) % W));
    end

    finish_run();
  end
endmodule